// File: doc/BRIEF.md
# Oversampled Manchester Bit Decoder

This block recovers data bits from a Manchester-coded serial line. A local clock samples the line at `OSR` samples per bit, where `OSR` is somewhat above four. Each cell holds the complement of its bit for the first half and the bit itself for the second half. The transition in the middle of the cell is the bit event, and the level after it is the decoded bit. When two neighbouring bits are equal, a transition also occurs at the start of the cell. That transition carries no data and must be rejected.

The line first passes through a two-flop synchronizer. A third flop holds the previous synchronized level, and the edge detector compares the two. A small state machine then decides which edges count. After it accepts an edge, it ignores every further edge for a lockout window of `(3*OSR)/4` samples, which covers the cell-boundary transition. The window ends before the earliest point at which the next mid-cell edge can arrive, allowing one sample of uncertainty. With `OSR` at 5 the lockout is 3 samples, the lock tolerance is 1 sample and the timeout is 7 samples.

The states are as follows:
- HUNT has no timing reference, and the first edge it sees is accepted (HUNT to LOCKOUT).
- LOCKOUT ignores edges. It moves to WAIT once `LOCK_LEN` samples have passed since the accepted edge (LOCKOUT to WAIT).
- WAIT accepts the next edge and re-arms the lockout (WAIT to LOCKOUT).
- If no edge arrives by `TMO_LEN` samples, WAIT falls back to HUNT and the lock flag drops (WAIT to HUNT, timeout).
- Reset forces HUNT from any state.

A streak tracker counts accepted edges that follow each other closely enough. It raises the lock flag once that count reaches `LOCK_N`.

Top module: `manch_decoder`

## Requirements
- R1: The line passes through two synchronizer flops. An accepted level change that is driven before rising edge k produces `bit_valid_o` visible after rising edge k+2.
- R2: On each valid pulse, `bit_o` equals the line level after the accepted edge. `bit_o` does not change while `bit_valid_o` is low.
- R3: A Manchester stream of `OSR` samples per bit decodes to the sent bit sequence, one valid pulse per bit and in order. In the stream, each cell holds the inverted bit for the first `OSR/2` samples and then the bit. The idle line is 0, and the first bit is 1. Boundary transitions between equal bits produce no output.
- R4: After an edge is accepted, any edge 1 to `LOCK_LEN` (3) samples later is ignored: no valid pulse and no change of `bit_o`. An edge `LOCK_LEN+1` or more samples later is accepted.
- R5: `bit_valid_o` is high for exactly one clock per accepted edge.
- R6: `locked_o` rises on the accepted edge that completes a streak of `LOCK_N` (4) edges. In that streak, each edge after the first follows the previous one by at most `OSR+TOL` (6) samples. A longer gap restarts the streak at one.
- R7: If no edge arrives within `TMO_LEN` (7) samples of the last accepted edge, the decoder returns to HUNT with `locked_o` low. The next edge is accepted as a new first edge.
- R8: A synchronous active-high reset clears `bit_o`, `bit_valid_o`, `locked_o`, the synchronizer and the lockout count, and leaves the decoder in HUNT. The first edge after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, `OSR` times the bit rate |
| rst_i | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous Manchester-coded line |
| bit_o | output | 1 | Last decoded data bit |
| bit_valid_o | output | 1 | One-cycle strobe for a newly decoded bit |
| locked_o | output | 1 | Decoder is locked to the bit stream |

## Verification
A line change driven in the cycle after bench cycle c must give a valid pulse that the bench samples in cycle c+3. That delay is two synchronizer flops plus the output register. The lock flag changes in the same cycle as the valid pulse that completes or breaks the streak.

The bench drives inputs and samples outputs on the falling clock edge. It records the cycle number, data and lock state of every valid pulse. It then compares these records against cycle numbers that it computes from the toggle times it chose. It sweeps the gap between two edges from 1 to 9 samples, and the spacing of an edge chain from 4 to 8 samples. After each sweep step it holds the line quiet so that timeouts occur at known points.

// File: rtl/manch_pkg.sv
package manch_pkg;

    // Decoder FSM states
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,   // no timing reference, first edge is taken
        ST_LOCKOUT = 2'd1,   // edges ignored after an accepted one
        ST_WAIT    = 2'd2    // window open for the next mid-cell edge
    } dec_state_e;

endpackage

// File: rtl/manch_sync_edge.sv
module manch_sync_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_i,
    output logic level_o,
    output logic edge_o
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-flop synchronizer plus one history flop
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign edge_o  = sync_q ^ prev_q;

endmodule

// File: rtl/manch_lock_track.sv
module manch_lock_track #(
    parameter int GAP_MAX = 6,
    parameter int LOCK_N  = 4,
    parameter int CW      = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          accept_i,
    input  logic          first_i,
    input  logic [CW-1:0] gap_i,
    input  logic          clear_i,
    output logic          lock_o
);

    localparam int SW = $clog2(LOCK_N + 1);

    logic [SW-1:0] streak_q;
    logic [SW-1:0] streak_nx;

    always_comb begin
        streak_nx = streak_q;
        if (accept_i) begin
            if (first_i || (gap_i > CW'(GAP_MAX)))
                streak_nx = SW'(1);
            else if (streak_q < SW'(LOCK_N))
                streak_nx = streak_q + SW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            streak_q <= '0;
            lock_o   <= 1'b0;
        end else if (accept_i) begin
            streak_q <= streak_nx;
            lock_o   <= (streak_nx == SW'(LOCK_N));
        end
    end

    // R6: lock can only come up on an accepted edge
    a_r6_lock_rise_on_accept: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_o) |-> $past(accept_i));

    // R7: a timeout clears the lock flag
    a_r7_timeout_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_i |=> !lock_o);

endmodule

// File: rtl/manch_decoder.sv
module manch_decoder #(
    parameter int OSR    = 5,
    parameter int TOL    = 1,
    parameter int LOCK_N = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_i,
    output logic bit_o,
    output logic bit_valid_o,
    output logic locked_o
);
    import manch_pkg::*;

    localparam int LOCK_LEN = (3 * OSR) / 4;
    localparam int TMO_LEN  = (3 * OSR) / 2;
    localparam int GAP_MAX  = OSR + TOL;
    localparam int CW       = $clog2(TMO_LEN + 2);

    logic          level_w;
    logic          edge_w;
    dec_state_e    state_q;
    dec_state_e    state_nx;
    logic [CW-1:0] since_q;
    logic          accept_w;
    logic          timeout_w;

    manch_sync_edge u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .line_i  (line_i),
        .level_o (level_w),
        .edge_o  (edge_w)
    );

    // Next-state decision
    always_comb begin
        state_nx  = state_q;
        accept_w  = 1'b0;
        timeout_w = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (edge_w) begin
                    accept_w = 1'b1;
                    state_nx = ST_LOCKOUT;
                end
            end
            ST_LOCKOUT: begin
                if (since_q == CW'(LOCK_LEN))
                    state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (edge_w) begin
                    accept_w = 1'b1;
                    state_nx = ST_LOCKOUT;
                end else if (since_q == CW'(TMO_LEN)) begin
                    timeout_w = 1'b1;
                    state_nx  = ST_HUNT;
                end
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    // State register and sample counter since the last accepted edge
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_HUNT;
            since_q <= '0;
        end else begin
            state_q <= state_nx;
            if (accept_w)
                since_q <= CW'(1);
            else if (state_q != ST_HUNT)
                since_q <= since_q + CW'(1);
        end
    end

    // Outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bit_o       <= 1'b0;
            bit_valid_o <= 1'b0;
        end else begin
            bit_valid_o <= accept_w;
            if (accept_w)
                bit_o <= level_w;
        end
    end

    manch_lock_track #(
        .GAP_MAX (GAP_MAX),
        .LOCK_N  (LOCK_N),
        .CW      (CW)
    ) u_lock (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .accept_i (accept_w),
        .first_i  (state_q == ST_HUNT),
        .gap_i    (since_q),
        .clear_i  (timeout_w),
        .lock_o   (locked_o)
    );

    // R5: the strobe never lasts two cycles
    a_r5_valid_single: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_valid_o |=> !bit_valid_o);

    // R4: nothing is accepted while locked out
    a_r4_lockout_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LOCKOUT) |=> !bit_valid_o);

    // R2: data holds between strobes
    a_r2_data_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !bit_valid_o |-> $stable(bit_o));

    // R7: hunting implies not locked
    a_r7_hunt_unlocked: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_HUNT) |-> !locked_o);

    // R1: every strobe follows a detected edge
    a_r1_valid_after_edge: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_valid_o |-> $past(edge_w));

endmodule

// File: tb/test_manch_decoder.sv
`timescale 1ns/1ps
module test_manch_decoder;

    localparam int OSR      = 5;
    localparam int HALF     = 2;   // samples of inverted level per cell
    localparam int LOCKOUT  = 3;
    localparam int GAPMAX   = 6;
    localparam int TMO      = 7;
    localparam int LOCKN    = 4;
    localparam int LAT      = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst;
    logic line;
    wire  bit_w, valid_w, lock_w;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int nrx   = 0;
    logic rxd [256];
    int   rxc [256];
    logic rxl [256];

    manch_decoder i_manch_decoder (
        .clk_i       (clk),
        .rst_i       (rst),
        .line_i      (line),
        .bit_o       (bit_w),
        .bit_valid_o (valid_w),
        .locked_o    (lock_w)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (valid_w) begin
            if (nrx < 256) begin
                rxd[nrx] = bit_w;
                rxc[nrx] = cyc;
                rxl[nrx] = lock_w;
            end
            nrx++;
        end
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        line = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        nrx = 0;
    endtask

    task automatic send_bit(input logic b);
        for (int i = 0; i < OSR; i++) begin
            line = (i < HALF) ? ~b : b;
            tick();
        end
    endtask

    task automatic run_stream(input logic [31:0] pat, input int n, input string tag);
        int c0;
        do_reset();
        tick();
        c0 = cyc;
        for (int i = 0; i < n; i++) send_bit(pat[i]);
        line = pat[n-1];
        repeat (12) tick();
        check(nrx == n, {"R3 count ", tag}, nrx, n);
        for (int i = 0; i < n && i < nrx; i++) begin
            check(rxd[i] == pat[i], {"R3 bit ", tag}, rxd[i], pat[i]);
            check(rxl[i] == (i >= LOCKN - 1), {"R6 lock ", tag}, rxl[i], (i >= LOCKN - 1));
            // mid edge of cell i is driven after cycle c0 + i*OSR + HALF
            check(rxc[i] == c0 + i*OSR + HALF + LAT, {"R1 timing ", tag},
                  rxc[i], c0 + i*OSR + HALF + LAT);
            if (i > 0)
                check(rxc[i] - rxc[i-1] == OSR, {"R5 spacing ", tag}, rxc[i] - rxc[i-1], OSR);
        end
        check(lock_w == 1'b0, {"R7 idle unlock ", tag}, lock_w, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0, c1, expn;
        rst  = 1'b1;
        line = 1'b0;
        repeat (3) tick();
        check(bit_w == 1'b0,   "R8 reset bit",   bit_w, 0);
        check(valid_w == 1'b0, "R8 reset valid", valid_w, 0);
        check(lock_w == 1'b0,  "R8 reset lock",  lock_w, 0);
        line = 1'b1;
        repeat (4) tick();
        check(valid_w == 1'b0, "R8 line ignored in reset", valid_w, 0);
        line = 1'b0;
        repeat (4) tick();

        // Streams: bit i is pat[i], first bit is 1
        run_stream(32'h0000_00FF, 8,  "ones");
        run_stream(32'h0000_0001, 10, "zeros");
        run_stream(32'h0000_5555, 12, "alt");
        run_stream(32'h0000_B3A5, 16, "mixed");
        run_stream(32'h0000_F0E1, 16, "runs");

        // Gap sweep: first edge then a second edge g samples later
        for (int g = 1; g <= 9; g++) begin
            do_reset();
            tick();
            line = 1'b1;
            c0 = cyc;
            repeat (g) tick();
            line = 1'b0;
            c1 = cyc;
            repeat (14) tick();
            expn = (g > LOCKOUT) ? 2 : 1;
            check(nrx == expn, "R4 gap accept count", nrx, expn);
            check(rxc[0] == c0 + LAT, "R8 first edge after reset", rxc[0], c0 + LAT);
            check(rxd[0] == 1'b1, "R2 first data", rxd[0], 1);
            if (g > LOCKOUT) begin
                check(rxc[1] == c1 + LAT, "R4 second edge timing", rxc[1], c1 + LAT);
                check(rxd[1] == 1'b0, "R2 second data", rxd[1], 0);
            end else begin
                check(bit_w == 1'b1, "R4 ignored edge keeps bit", bit_w, 1);
            end
        end

        // Lock sweep: chain of six edges spaced d samples apart
        for (int d = 4; d <= 8; d++) begin
            do_reset();
            tick();
            line = 1'b1;
            for (int k = 0; k < 5; k++) begin
                repeat (d) tick();
                line = ~line;
            end
            repeat (4) tick();
            check(nrx == 6, "R6 chain edges", nrx, 6);
            check(lock_w == (d <= GAPMAX), "R6 chain lock", lock_w, (d <= GAPMAX));
            if (d <= GAPMAX)
                check(rxl[LOCKN-2] == 1'b0 && rxl[LOCKN-1] == 1'b1, "R6 lock edge index",
                      rxl[LOCKN-1], 1);
            repeat (TMO + 4) tick();
            check(lock_w == 1'b0, "R7 timeout unlock", lock_w, 0);
            nrx = 0;
            line = ~line;
            c0 = cyc;
            repeat (6) tick();
            check(nrx == 1 && rxc[0] == c0 + LAT, "R7 reacquire", nrx, 1);
            check(lock_w == 1'b0, "R7 streak restarted", lock_w, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule